// File: doc/BRIEF.md
# Invertible-Operand ALU with Flags

This block is a purely combinational arithmetic logic unit of parameterised width, four bits by default. It takes two operands and a two-bit operation select. From these it returns a result word and four status flags: carry, signed overflow, sign and zero. The select chooses between bitwise AND, bitwise OR and the output of a single ripple-carry adder. A function bit turns the adder path into a subtractor: the second operand is complemented and a carry-in of one is injected.

Each operand has its own invert control, applied before both the logic gates and the adder. With both inverts set, the AND path yields NOR and the OR path yields NAND. Inverting only the first operand on the adder path yields reverse subtraction, second operand minus first. The carry-in is set when exactly one operand enters the adder complemented. Overflow compares the carry entering the sign stage with the carry leaving it.

Top module: `inv_alu`

## Requirements
- R1: With sel_i = 2'b00 the result is the bitwise AND of the two conditioned operands, where an operand is bitwise complemented when its invert input is 1.
- R2: With sel_i = 2'b01 the result is the bitwise OR of the two conditioned operands.
- R3: With sel_i = 2'b10, sub_i = 0 and no invert asserted, the result is (a_i + b_i) mod 2^W and c_o is the carry out of the top bit.
- R4: With sel_i = 2'b10, sub_i = 1 and no invert asserted, the result is (a_i - b_i) mod 2^W and c_o is 1 exactly when a_i >= b_i unsigned.
- R5: With sel_i = 2'b10, sub_i = 0, inv_a_i = 1 and inv_b_i = 0, the result is (b_i - a_i) mod 2^W and c_o is 1 exactly when b_i >= a_i unsigned.
- R6: On sel_i = 2'b10 the second operand is complemented when inv_b_i or sub_i is 1, the first when inv_a_i is 1; the carry-in is 1 exactly when one of the two is complemented; result and c_o are the sum of both conditioned operands and the carry-in.
- R7: On sel_i = 2'b10, v_o is 1 exactly when the carry into the top bit differs from the carry out of it, which equals two's-complement overflow of the conditioned operands.
- R8: n_o equals the top bit of res_o and z_o is 1 exactly when every bit of res_o is 0, for every select.
- R9: With sel_i = 2'b00 or 2'b01, c_o and v_o are 0 and sub_i has no effect on any output.
- R10: With sel_i = 2'b11 the result is all zeros, c_o, v_o and n_o are 0 and z_o is 1.
- R11: With both invert inputs at 1, sel_i = 2'b00 gives NOR of the raw operands and sel_i = 2'b01 gives NAND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| inv_a_i | input | 1 | Complement the first operand before use |
| inv_b_i | input | 1 | Complement the second operand before use |
| sel_i | input | 2 | Operation select: 00 AND, 01 OR, 10 adder, 11 unused |
| sub_i | input | 1 | Adder path: 0 add, 1 subtract second from first |
| res_o | output | W | Result word |
| c_o | output | 1 | Carry out of the top adder stage |
| v_o | output | 1 | Signed overflow |
| n_o | output | 1 | Sign of the result |
| z_o | output | 1 | Result is zero |

## Verification
The block holds no state, so a wrong internal value is any miswired carry, inversion or select path, and it shows on the ports in the same cycle its inputs are applied. A broken carry link in the ripple chain appears as a wrong sum and carry for those operand pairs that propagate through that stage. A wrong carry-in choice shows as an off-by-one result on subtraction or reverse subtraction. A swapped overflow source shows as v_o disagreeing with overflow computed from operand signs. Sweeping every operand pair under every select, function and invert combination exposes each of these faults at once.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND   = 2'b00,
        SEL_OR    = 2'b01,
        SEL_ARITH = 2'b10,
        SEL_NONE  = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } alu_flags_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_a_i,
    input  logic         inv_b_i,
    input  alu_sel_e     sel_i,
    input  logic         sub_i,
    output logic [W-1:0] opa_o,
    output logic [W-1:0] opb_o,
    output logic         cin_o
);

    typedef struct packed {
        logic         flip_a;
        logic         flip_b;
        logic [W-1:0] opa;
        logic [W-1:0] opb;
        logic         cin;
    } prep_t;

    prep_t prep_d;

    always_comb begin
        prep_d        = '0;
        prep_d.flip_a = inv_a_i;
        // subtract complements the second operand on the adder path only
        prep_d.flip_b = inv_b_i | ((sel_i == SEL_ARITH) & sub_i);
        prep_d.opa    = prep_d.flip_a ? ~a_i : a_i;
        prep_d.opb    = prep_d.flip_b ? ~b_i : b_i;
        // one complemented operand needs +1 to become a negation
        prep_d.cin    = (sel_i == SEL_ARITH) & (prep_d.flip_a ^ prep_d.flip_b);
    end

    assign opa_o = prep_d.opa;
    assign opb_o = prep_d.opb;
    assign cin_o = prep_d.cin;

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_top_in_o,
    output logic         c_out_o
);

    logic [W:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar g = 0; g < W; g++) begin : g_stage
        logic prop_d;
        assign prop_d       = x_i[g] ^ y_i[g];
        assign sum_o[g]     = prop_d ^ carry_d[g];
        assign carry_d[g+1] = (x_i[g] & y_i[g]) | (prop_d & carry_d[g]);
    end

    assign c_top_in_o = carry_d[W-1];
    assign c_out_o    = carry_d[W];

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
    import alu_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_sel_e     sel_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] sum_i,
    input  logic         c_top_in_i,
    input  logic         c_out_i,
    output logic [W-1:0] res_o,
    output alu_flags_t   flags_o
);

    typedef struct packed {
        logic [W-1:0] res;
        alu_flags_t   flags;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d = '0;
        unique case (sel_i)
            SEL_AND:   out_d.res = opa_i & opb_i;
            SEL_OR:    out_d.res = opa_i | opb_i;
            SEL_ARITH: begin
                out_d.res     = sum_i;
                out_d.flags.c = c_out_i;
                out_d.flags.v = c_top_in_i ^ c_out_i;
            end
            default:   out_d.res = '0;
        endcase
        out_d.flags.n = out_d.res[W-1];
        out_d.flags.z = ~|out_d.res;
    end

    assign res_o   = out_d.res;
    assign flags_o = out_d.flags;

endmodule

// File: rtl/inv_alu.sv
module inv_alu
    import alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_a_i,
    input  logic         inv_b_i,
    input  logic [1:0]   sel_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o,
    output logic         n_o,
    output logic         z_o
);

    alu_sel_e     sel_d;
    logic [W-1:0] opa_d;
    logic [W-1:0] opb_d;
    logic         cin_d;
    logic [W-1:0] sum_d;
    logic         c_top_in_d;
    logic         c_out_d;
    alu_flags_t   flags_d;

    assign sel_d = alu_sel_e'(sel_i);

    alu_operand_prep #(.W(W)) u_prep (
        .a_i     (a_i),
        .b_i     (b_i),
        .inv_a_i (inv_a_i),
        .inv_b_i (inv_b_i),
        .sel_i   (sel_d),
        .sub_i   (sub_i),
        .opa_o   (opa_d),
        .opb_o   (opb_d),
        .cin_o   (cin_d)
    );

    alu_ripple_adder #(.W(W)) u_add (
        .x_i        (opa_d),
        .y_i        (opb_d),
        .cin_i      (cin_d),
        .sum_o      (sum_d),
        .c_top_in_o (c_top_in_d),
        .c_out_o    (c_out_d)
    );

    alu_result_sel #(.W(W)) u_sel (
        .sel_i      (sel_d),
        .opa_i      (opa_d),
        .opb_i      (opb_d),
        .sum_i      (sum_d),
        .c_top_in_i (c_top_in_d),
        .c_out_i    (c_out_d),
        .res_o      (res_o),
        .flags_o    (flags_d)
    );

    assign c_o = flags_d.c;
    assign v_o = flags_d.v;
    assign n_o = flags_d.n;
    assign z_o = flags_d.z;

endmodule

// File: rtl/inv_alu_checker.sv
module inv_alu_checker #(
    parameter int W = 4
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         inv_a_i,
    input logic         inv_b_i,
    input logic [1:0]   sel_i,
    input logic         sub_i,
    input logic [W-1:0] res_o,
    input logic         c_o,
    input logic         v_o,
    input logic         n_o,
    input logic         z_o
);

    logic plain_d;
    assign plain_d = (sel_i == 2'b10) && !inv_a_i && !inv_b_i;

    always_comb begin
        AST_ZERO_FLAG: assert (z_o == (res_o == '0));                       // R8
        AST_SIGN_FLAG: assert (n_o == res_o[W-1]);                          // R8
        if (sel_i[1] == 1'b0) begin
            AST_LOGIC_NO_CV: assert (!c_o && !v_o);                         // R9
        end
        if (sel_i == 2'b11) begin
            AST_UNUSED_ZERO: assert (res_o == '0);                          // R10
        end
        if (plain_d && !sub_i) begin
            AST_NO_OVERFLOW: assert (v_o == ((a_i[W-1] == b_i[W-1]) &&
                                             (res_o[W-1] != a_i[W-1])));    // R7
        end
        if (plain_d && sub_i) begin
            AST_SUB_CARRY: assert (c_o == (a_i >= b_i));                    // R4
        end
    end

endmodule

bind inv_alu inv_alu_checker #(.W(W)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .inv_a_i (inv_a_i),
    .inv_b_i (inv_b_i),
    .sel_i   (sel_i),
    .sub_i   (sub_i),
    .res_o   (res_o),
    .c_o     (c_o),
    .v_o     (v_o),
    .n_o     (n_o),
    .z_o     (z_o)
);

// File: tb/inv_alu_test.sv
module inv_alu_test;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;
    localparam int MASK = SPAN - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic         ia, ib, sub;
    logic [1:0]   sel;
    logic [W-1:0] res;
    logic         c, v, n, z;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    inv_alu #(.W(W)) uut (
        .a_i(a), .b_i(b), .inv_a_i(ia), .inv_b_i(ib),
        .sel_i(sel), .sub_i(sub),
        .res_o(res), .c_o(c), .v_o(v), .n_o(n), .z_o(z)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d sel=%0d sub=%0d ia=%0d ib=%0d)",
                     tag, what, act, exp, a, b, sel, sub, ia, ib);
        end
    endtask

    task automatic apply(input int av, input int bv, input int sv, input int fv, input int iav, input int ibv);
        int oa, ob, cin, full, er, ec, ev, en, ez;
        bit arith, flip_b;
        string tag_r, tag_c, tag_v;
        @(negedge clk);
        a = W'(av); b = W'(bv); sel = 2'(sv); sub = fv[0]; ia = iav[0]; ib = ibv[0];
        // behavioural expectation
        arith  = (sv == 2);
        flip_b = (ibv != 0) || (arith && fv != 0);
        oa     = (iav != 0) ? (~av & MASK) : av;
        ob     = flip_b ? (~bv & MASK) : bv;
        cin    = (arith && ((iav != 0) != flip_b)) ? 1 : 0;
        ec = 0; ev = 0;
        case (sv)
            0: er = oa & ob;
            1: er = oa | ob;
            2: begin
                full = oa + ob + cin;
                er   = full & MASK;
                ec   = (full >> W) & 1;
                // signed overflow from operand and result signs
                ev   = ((oa >> (W-1)) == (ob >> (W-1)) && (er >> (W-1)) != (oa >> (W-1))) ? 1 : 0;
            end
            default: er = 0;
        endcase
        en = (er >> (W-1)) & 1;
        ez = (er == 0) ? 1 : 0;
        if (sv == 3) begin tag_r = "R10"; tag_c = "R10"; tag_v = "R10"; end
        else if (sv < 2) begin
            tag_r = (iav != 0 && ibv != 0) ? "R11" : (sv == 0 ? "R1" : "R2");
            tag_c = "R9"; tag_v = "R9";   // R9: sub has no effect, C and V stay 0
        end else begin
            if (iav == 0 && ibv == 0 && fv == 0)      tag_r = "R3";
            else if (iav == 0 && ibv == 0)            tag_r = "R4";
            else if (iav != 0 && ibv == 0 && fv == 0) tag_r = "R5";
            else                                      tag_r = "R6";
            tag_c = tag_r; tag_v = "R7";
        end
        @(posedge clk);
        #2;
        check(tag_r, "res", int'(res), er);
        check(tag_c, "c",   int'(c),   ec);
        check(tag_v, "v",   int'(v),   ev);
        check("R8",  "n",   int'(n),   en);
        check("R8",  "z",   int'(z),   ez);
        if (arith && iav == 0 && ibv == 0) begin
            int sa, sb, sr;
            sa = (av >= SPAN/2) ? av - SPAN : av;
            sb = (bv >= SPAN/2) ? bv - SPAN : bv;
            sr = (fv != 0) ? sa - sb : sa + sb;
            check("R7", "v_signed", int'(v), (sr < -SPAN/2 || sr > SPAN/2 - 1) ? 1 : 0);
        end
        if (fv != 0 && iav == 0 && ibv == 0 && arith)
            check("R4", "c_noborrow", int'(c), (av >= bv) ? 1 : 0);
        if (fv == 0 && iav != 0 && ibv == 0 && arith)
            check("R5", "c_noborrow", int'(c), (bv >= av) ? 1 : 0);
    endtask

    initial begin
        a = '0; b = '0; ia = 0; ib = 0; sel = 2'b00; sub = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // quiet state after reset: all-zero inputs give zero result
        check("R8", "z_reset", int'(z), 1);
        check("R1", "res_reset", int'(res), 0);
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 2; f++)
                for (int xa = 0; xa < 2; xa++)
                    for (int xb = 0; xb < 2; xb++)
                        for (int av = 0; av < SPAN; av++)
                            for (int bv = 0; bv < SPAN; bv++)
                                apply(av, bv, s, f, xa, xb);
        // corner: most negative minus one overflows
        apply(SPAN/2, 1, 2, 1, 0, 0);
        check("R7", "v_corner", int'(v), 1);
        // corner: reverse subtract of equal operands yields zero with carry
        apply(5, 5, 2, 0, 1, 0);
        check("R5", "res_corner", int'(res), 0);
        check("R5", "c_corner", int'(c), 1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule